// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-port synchronous static RAM with a shared data path. The word is four 9-bit byte lanes (8 data bits plus a parity bit each). Address, chip enables, address strobes, advance, write controls and write data are all captured on the rising clock edge. Read data is not delayed by an output register: the word at the captured address appears on the output during the cycle that follows that edge. Bursts of four beats run in a 2-1-1-1 pattern, and a 2-bit counter generates the three follow-on addresses in either linear or interleaved order.

New addresses are loaded through one of two strobes. The processor-side strobe is honoured only while the primary enable is active, always starts a read, and wins over the controller-side strobe. The controller-side strobe can start a read or a write. Selection takes three enables: an active-low primary enable, an active-high expansion enable and an active-low expansion enable. Output enable and the sleep input act without a clock edge. The shared data pins are modelled as a data-out bus plus a drive-enable flag. When the flag is low the bus reads zero, which stands for high impedance.

The depth is set by `ADDR_W`. With `ADDR_W = 15` the block is the full 32K x 36 array. The default is smaller so that the model elaborates quickly.

Top module: `fsb_sram`

## Requirements
- R1: A synchronous reset clears the selection, the burst state and the read-valid state. In the cycle after a reset edge `q_en_o` is 0 and `q_o` is 0, and it stays so until a new selected read is loaded by a strobe.
- R2: A selected read loaded at edge N puts the array word at the loaded address on `q_o`, with `q_en_o` = 1, in the cycle between edge N and edge N+1. A read that directly follows a write of the same address returns the newly written word.
- R3: With `gw_n_i` = 0 in a write-capable cycle, all four lanes of `d_i` are written to the addressed word. `q_en_o` is 0 in the cycle after any write.
- R4: With `gw_n_i` = 1 and `bw_en_n_i` = 0, lane l (bits 9l+8 down to 9l of the word) is written only when `lane_we_n_i[l]` = 0. The other lanes keep their previous contents.
- R5: When `gw_n_i` = 1 and either `bw_en_n_i` = 1 or all `lane_we_n_i` bits are 1, the cycle is a read, and the array is unchanged.
- R6: A load selects the device only if `ce_n_i` = 0, `ce2_i` = 1 and `ce3_n_i` = 0. A deselected load, and the continuation cycles after it, neither read nor write, and they keep `q_en_o` at 0.
- R7: Chip enables are looked at only when a strobe loads an address. Changes to them during burst continuation cycles have no effect.
- R8: The processor strobe (`ads_proc_n_i` = 0) is acted on only when `ce_n_i` = 0. It then takes priority over the controller strobe and always starts a read, ignoring all write inputs. When `ce_n_i` = 1 it is ignored.
- R9: In a cycle with no strobe, `adv_n_i` = 0 advances the 2-bit beat counter. The low two address bits are (start + k) mod 4 when `seq_mode_i` = 0 and start XOR k when `seq_mode_i` = 1. After the fourth beat the counter wraps to the start, and the upper address bits never change.
- R10: In a cycle with no strobe, `adv_n_i` = 1 holds the burst address, so the same word is accessed again.
- R11: `oe_n_i` = 1 forces `q_en_o` to 0 and `q_o` to 0 at once, without a clock edge. It does not stop the burst counter from advancing.
- R12: `sleep_i` = 1 forces `q_en_o` to 0 at once. Every edge during sleep ignores strobes and writes, keeps the array contents, and deselects the device. After sleep ends, `q_en_o` stays 0 until a new selected read is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address, captured on a strobe |
| ce_n_i | input | 1 | Primary chip enable, active low; also gates the processor strobe |
| ce2_i | input | 1 | Expansion chip enable, active high |
| ce3_n_i | input | 1 | Expansion chip enable, active low |
| ads_proc_n_i | input | 1 | Processor address strobe, active low |
| ads_ctrl_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gw_n_i | input | 1 | Global write of all lanes, active low |
| bw_en_n_i | input | 1 | Byte-write enable, active low |
| lane_we_n_i | input | LANES | Per-lane write selects, active low, bit l for lane l |
| seq_mode_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous sleep request, active high |
| d_i | input | LANES*LANE_W | Write data |
| q_o | output | LANES*LANE_W | Read data; zero while not driven |
| q_en_o | output | 1 | High while the data pins are driven |

## Verification
Two sets of functions share a cycle here. Burst advance can coincide with output-enable removal, and sleep can coincide with a write strobe. The bench provokes the first by raising `oe_n_i` on an advancing beat. It checks that the output goes dark in that cycle and that the next held beat shows the advanced word. It provokes the second by issuing a selected global write while `sleep_i` is high, then reading that address after wake-up and comparing it with the old contents. It also toggles output enable and sleep in mid-cycle, without a clock edge, to judge that their effect is immediate.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    LD_HOLD = 2'd0,
    LD_PROC = 2'd1,
    LD_CTRL = 2'd2
  } ld_kind_e;

  // low address bits of beat k of a burst that started at 'start'
  function automatic logic [BEAT_W-1:0] beat_low(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] k,
    input logic              ilv
  );
    logic [BEAT_W-1:0] r;
    if (ilv) r = start ^ k;
    else     r = start + k;
    return r;
  endfunction

endpackage

// File: rtl/fsb_wr_decode.sv
module fsb_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             gw_n,
  input  logic             bw_en_n,
  input  logic [LANES-1:0] lane_we_n,
  output logic [LANES-1:0] lane_we,
  output logic             any_we
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb lane_we[l] = !gw_n || (!bw_en_n && !lane_we_n[l]);
  end

  always_comb any_we = |lane_we;

endmodule

// File: rtl/fsb_addr_ctl.sv
module fsb_addr_ctl
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              adv_n,
  input  logic              seq_mode,
  input  logic              sleep,
  input  logic              wr_req,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_wr,
  output logic              acc_rd
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q, base_n;
  logic [BEAT_W-1:0] cnt_q, cnt_n;
  logic              sel_q, sel_n;
  logic              ce_ok, acc, wr_ok;
  ld_kind_e          kind;

  always_comb begin
    ce_ok = !ce_n && ce2 && !ce3_n;
    if (!ads_proc_n && !ce_n)  kind = LD_PROC;
    else if (!ads_ctrl_n)      kind = LD_CTRL;
    else                       kind = LD_HOLD;
  end

  always_comb begin
    base_n = base_q;
    cnt_n  = cnt_q;
    sel_n  = sel_q;
    acc    = 1'b0;
    wr_ok  = 1'b0;
    if (rst) begin
      acc = 1'b0;
    end else if (sleep) begin
      sel_n = 1'b0;
    end else if (kind != LD_HOLD) begin
      base_n = addr_i;
      cnt_n  = '0;
      sel_n  = ce_ok;
      acc    = ce_ok;
      wr_ok  = (kind == LD_CTRL);
    end else begin
      if (sel_q && !adv_n) cnt_n = cnt_q + 1'b1;
      acc   = sel_q;
      wr_ok = 1'b1;
    end
  end

  always_comb begin
    acc_addr = {base_n[ADDR_W-1 -: HI_W], beat_low(base_n[BEAT_W-1:0], cnt_n, seq_mode)};
    acc_wr   = acc && wr_ok && wr_req;
    acc_rd   = acc && !(wr_ok && wr_req);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
      sel_q  <= sel_n;
    end
  end

endmodule

// File: rtl/fsb_array.sv
module fsb_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        we,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    rd_en,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[l]) mem[addr] <= wdata[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rd_en) rd_q <= mem[addr];
    end

    always_comb rdata[l*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/fsb_out_gate.sv
module fsb_out_gate #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_fire,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] q,
  output logic              q_en
);

  logic rd_valid_q;

  always_ff @(posedge clk) begin
    if (rst) rd_valid_q <= 1'b0;
    else     rd_valid_q <= rd_fire;
  end

  always_comb begin
    q_en = rd_valid_q && !oe_n && !sleep;
    q    = q_en ? rdata : '0;
  end

endmodule

// File: rtl/fsb_sram.sv
module fsb_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    ce_n_i,
  input  logic                    ce2_i,
  input  logic                    ce3_n_i,
  input  logic                    ads_proc_n_i,
  input  logic                    ads_ctrl_n_i,
  input  logic                    adv_n_i,
  input  logic                    gw_n_i,
  input  logic                    bw_en_n_i,
  input  logic [LANES-1:0]        lane_we_n_i,
  input  logic                    seq_mode_i,
  input  logic                    oe_n_i,
  input  logic                    sleep_i,
  input  logic [LANES*LANE_W-1:0] d_i,
  output logic [LANES*LANE_W-1:0] q_o,
  output logic                    q_en_o
);

  localparam int DATA_W = LANES * LANE_W;

  logic [LANES-1:0]  lane_we;
  logic              any_we;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_wr, acc_rd;
  logic [LANES-1:0]  arr_we;
  logic [DATA_W-1:0] rdata;

  fsb_wr_decode #(.LANES(LANES)) u_wr_decode (
    .gw_n      (gw_n_i),
    .bw_en_n   (bw_en_n_i),
    .lane_we_n (lane_we_n_i),
    .lane_we   (lane_we),
    .any_we    (any_we)
  );

  fsb_addr_ctl #(.ADDR_W(ADDR_W)) u_addr_ctl (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (addr_i),
    .ce_n       (ce_n_i),
    .ce2        (ce2_i),
    .ce3_n      (ce3_n_i),
    .ads_proc_n (ads_proc_n_i),
    .ads_ctrl_n (ads_ctrl_n_i),
    .adv_n      (adv_n_i),
    .seq_mode   (seq_mode_i),
    .sleep      (sleep_i),
    .wr_req     (any_we),
    .acc_addr   (acc_addr),
    .acc_wr     (acc_wr),
    .acc_rd     (acc_rd)
  );

  always_comb arr_we = acc_wr ? lane_we : '0;

  fsb_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .addr  (acc_addr),
    .we    (arr_we),
    .wdata (d_i),
    .rd_en (acc_rd),
    .rdata (rdata)
  );

  fsb_out_gate #(.DATA_W(DATA_W)) u_out_gate (
    .clk     (clk),
    .rst     (rst),
    .rd_fire (acc_rd),
    .oe_n    (oe_n_i),
    .sleep   (sleep_i),
    .rdata   (rdata),
    .q       (q_o),
    .q_en    (q_en_o)
  );

endmodule

// File: rtl/fsb_sram_chk.sv
module fsb_sram_chk (
  input logic clk,
  input logic rst,
  input logic ce_n_i,
  input logic ce2_i,
  input logic ce3_n_i,
  input logic ads_proc_n_i,
  input logic ads_ctrl_n_i,
  input logic gw_n_i,
  input logic oe_n_i,
  input logic sleep_i,
  input logic q_en_o
);

  // R1: the cycle after a reset edge is dark
  a_r1_reset_dark: assert property (@(posedge clk) rst |=> !q_en_o);

  // R11: output enable high never lets the pins be driven
  a_r11_oe_blocks: assert property (@(posedge clk) disable iff (rst)
    oe_n_i |-> !q_en_o);

  // R12: sleep never lets the pins be driven
  a_r12_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
    sleep_i |-> !q_en_o);

  // R12: first cycle after sleep without a new strobe stays dark
  a_r12_wake_dark: assert property (@(posedge clk) disable iff (rst)
    sleep_i ##1 (!sleep_i && ads_proc_n_i && ads_ctrl_n_i) |-> !q_en_o);

  // R6: controller load with expansion enable low is deselected
  a_r6_desel_dark: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && ads_proc_n_i && !ads_ctrl_n_i && !ce2_i) |=> !q_en_o);

  // R3: a controller-strobed global write leaves the next cycle dark
  a_r3_write_dark: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && ads_proc_n_i && !ads_ctrl_n_i && !gw_n_i) |=> !q_en_o);

  // R8: selected processor load is a read, driven when output enabled
  a_r8_proc_read: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && !ads_proc_n_i && !ce_n_i && ce2_i && !ce3_n_i)
      ##1 (!oe_n_i && !sleep_i) |-> q_en_o);

endmodule

bind fsb_sram fsb_sram_chk u_fsb_sram_chk (
  .clk          (clk),
  .rst          (rst),
  .ce_n_i       (ce_n_i),
  .ce2_i        (ce2_i),
  .ce3_n_i      (ce3_n_i),
  .ads_proc_n_i (ads_proc_n_i),
  .ads_ctrl_n_i (ads_ctrl_n_i),
  .gw_n_i       (gw_n_i),
  .oe_n_i       (oe_n_i),
  .sleep_i      (sleep_i),
  .q_en_o       (q_en_o)
);

// File: tb/test_fsb_sram.sv
module test_fsb_sram;

  localparam int AW = 8;
  localparam int DW = 36;
  localparam logic [1:0] NS = 2'd0, PS = 2'd1, CS = 2'd2;

  localparam logic [DW-1:0] A0 = 36'h1_2345_6789;
  localparam logic [DW-1:0] A1 = 36'h2_3456_789A;
  localparam logic [DW-1:0] A2 = 36'h3_4567_89AB;
  localparam logic [DW-1:0] A3 = 36'h4_5678_9ABC;
  localparam logic [DW-1:0] BB = 36'hF_EDCB_A987;
  localparam logic [DW-1:0] CC = 36'h5_5555_5555;
  // lanes 0 and 2 (bits 8:0 and 26:18)
  localparam logic [DW-1:0] MK = 36'h0_07FC_01FF;
  localparam logic [DW-1:0] MG = (BB & MK) | (A3 & ~MK);

  typedef struct packed {
    logic [1:0]    stb;
    logic          ce_n, ce2, ce3_n, adv_n, gw_n, bwe_n;
    logic [3:0]    lwe_n;
    logic          mode, oe_n, slp;
    logic [AW-1:0] addr;
    logic [DW-1:0] d;
    logic          en;
    logic [DW-1:0] q;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    '{CS,0,1,0,1,0,1,4'hF,0,0,0,8'h10,A0,0,36'h0,4'd3},  // R3 global write
    '{NS,0,1,0,0,0,1,4'hF,0,0,0,8'h00,A1,0,36'h0,4'd9},  // R9 burst write
    '{NS,0,1,0,0,0,1,4'hF,0,0,0,8'h00,A2,0,36'h0,4'd9},
    '{NS,0,1,0,0,0,1,4'hF,0,0,0,8'h00,A3,0,36'h0,4'd9},
    '{PS,0,1,0,1,1,1,4'hF,0,0,0,8'h10,0,1,A0,4'd2},      // R2 flow-through read
    '{NS,0,1,0,0,1,1,4'hF,0,0,0,8'h00,0,1,A1,4'd9},      // R9 linear
    '{NS,0,1,0,0,1,1,4'hF,0,0,0,8'h00,0,1,A2,4'd9},
    '{NS,0,1,0,0,1,1,4'hF,0,0,0,8'h00,0,1,A3,4'd9},
    '{NS,0,1,0,0,1,1,4'hF,0,0,0,8'h00,0,1,A0,4'd9},      // R9 wrap
    '{PS,0,1,0,1,1,1,4'hF,1,0,0,8'h12,0,1,A2,4'd9},      // R9 interleaved
    '{NS,0,1,0,0,1,1,4'hF,1,0,0,8'h00,0,1,A3,4'd9},
    '{NS,0,1,0,0,1,1,4'hF,1,0,0,8'h00,0,1,A0,4'd9},
    '{NS,0,1,0,0,1,1,4'hF,1,0,0,8'h00,0,1,A1,4'd9},
    '{PS,0,1,0,1,1,1,4'hF,0,0,0,8'h12,0,1,A2,4'd9},      // R9 linear from 2
    '{NS,0,1,0,0,1,1,4'hF,0,0,0,8'h00,0,1,A3,4'd9},
    '{NS,0,1,0,0,1,1,4'hF,0,0,0,8'h00,0,1,A0,4'd9},
    '{NS,0,1,0,1,1,1,4'hF,0,0,0,8'h00,0,1,A0,4'd10},     // R10 suspend
    '{CS,0,1,0,1,1,0,4'hA,0,0,0,8'h13,BB,0,36'h0,4'd4},  // R4 lanes 0,2
    '{PS,0,1,0,1,1,1,4'hF,0,0,0,8'h13,0,1,MG,4'd4},
    '{CS,0,1,0,1,1,1,4'h0,0,0,0,8'h13,CC,1,MG,4'd5},     // R5 bwe off
    '{CS,0,1,0,1,1,0,4'hF,0,0,0,8'h13,CC,1,MG,4'd5},     // R5 no lane
    '{PS,0,1,0,1,0,1,4'hF,0,0,0,8'h11,CC,1,A1,4'd8},     // R8 proc = read
    '{NS,0,1,0,1,1,1,4'hF,0,0,0,8'h00,0,1,A1,4'd8},
    '{PS,1,1,0,1,1,1,4'hF,0,0,0,8'h10,0,1,A1,4'd8},      // R8 ignored
    '{CS,0,0,0,1,0,1,4'hF,0,0,0,8'h10,CC,0,36'h0,4'd6},  // R6 ce2 low
    '{NS,0,1,0,0,0,1,4'hF,0,0,0,8'h00,CC,0,36'h0,4'd6},
    '{PS,0,1,0,1,1,1,4'hF,0,0,0,8'h10,0,1,A0,4'd6},
    '{CS,0,1,1,1,1,1,4'hF,0,0,0,8'h10,0,0,36'h0,4'd6},   // R6 ce3_n high
    '{PS,0,1,1,1,1,1,4'hF,0,0,0,8'h10,0,0,36'h0,4'd6},
    '{PS,0,1,0,1,1,1,4'hF,0,0,0,8'h10,0,1,A0,4'd7},      // R7
    '{NS,1,0,1,0,1,1,4'hF,0,0,0,8'h00,0,1,A1,4'd7},
    '{NS,0,1,0,0,1,1,4'hF,0,1,0,8'h00,0,0,36'h0,4'd11},  // R11 adv while dark
    '{NS,0,1,0,1,1,1,4'hF,0,0,0,8'h00,0,1,A2,4'd11},
    '{CS,1,1,0,1,1,1,4'hF,0,0,0,8'h10,0,0,36'h0,4'd12},  // R12 deselect
    '{CS,0,1,0,1,0,1,4'hF,0,0,1,8'h10,CC,0,36'h0,4'd12}, // R12 write in sleep
    '{NS,0,1,0,1,1,1,4'hF,0,0,1,8'h00,0,0,36'h0,4'd12},
    '{NS,0,1,0,0,1,1,4'hF,0,0,0,8'h00,0,0,36'h0,4'd12},
    '{PS,0,1,0,1,1,1,4'hF,0,0,0,8'h10,0,1,A0,4'd12},
    '{NS,0,1,0,1,1,1,4'hF,0,0,1,8'h00,0,0,36'h0,4'd12},
    '{NS,0,1,0,1,1,1,4'hF,0,0,0,8'h00,0,0,36'h0,4'd12}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr;
  logic          ce_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n;
  logic [3:0]    lwe_n;
  logic          mode, oe_n, slp;
  logic [DW-1:0] d, q;
  logic          q_en;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  fsb_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(9)) i_fsb_sram (
    .clk(clk), .rst(rst), .addr_i(addr), .ce_n_i(ce_n), .ce2_i(ce2),
    .ce3_n_i(ce3_n), .ads_proc_n_i(adsp_n), .ads_ctrl_n_i(adsc_n),
    .adv_n_i(adv_n), .gw_n_i(gw_n), .bw_en_n_i(bwe_n), .lane_we_n_i(lwe_n),
    .seq_mode_i(mode), .oe_n_i(oe_n), .sleep_i(slp), .d_i(d),
    .q_o(q), .q_en_o(q_en)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    adsp_n = !(v.stb == PS);
    adsc_n = !(v.stb == CS);
    ce_n = v.ce_n; ce2 = v.ce2; ce3_n = v.ce3_n; adv_n = v.adv_n;
    gw_n = v.gw_n; bwe_n = v.bwe_n; lwe_n = v.lwe_n; mode = v.mode;
    oe_n = v.oe_n; slp = v.slp; addr = v.addr; d = v.d;
  endtask

  localparam vec_t IDLE = '{NS,0,1,0,1,1,1,4'hF,0,0,0,8'h00,0,0,36'h0,4'd0};
  localparam vec_t RD10 = '{PS,0,1,0,1,1,1,4'hF,0,0,0,8'h10,0,1,A0,4'd2};

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    drive(IDLE);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset q_en", {35'd0, q_en}, 36'd0);
    chk("R1 reset q", q, 36'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      chk($sformatf("R%0d vec %0d q_en", VEC[i].req, i), {35'd0, q_en}, {35'd0, VEC[i].en});
      chk($sformatf("R%0d vec %0d q", VEC[i].req, i), q, VEC[i].q);
    end

    // R11 / R12 asynchronous effect inside a cycle
    drive(RD10);
    @(negedge clk);
    drive(IDLE);
    chk("R2 read before async", q, A0);
    oe_n = 1'b1; #1;
    chk("R11 async oe q_en", {35'd0, q_en}, 36'd0);
    chk("R11 async oe q", q, 36'd0);
    oe_n = 1'b0; #1;
    chk("R11 async oe release", q, A0);
    slp = 1'b1; #1;
    chk("R12 async sleep q_en", {35'd0, q_en}, 36'd0);
    slp = 1'b0; #1;
    chk("R12 async sleep release", q, A0);

    // R1 reset in mid-burst
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset q_en", {35'd0, q_en}, 36'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset no strobe", {35'd0, q_en}, 36'd0);
    drive(RD10);
    @(negedge clk);
    chk("R1 reload after reset", q, A0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule